// File: doc/BRIEF.md
# Leaf Page-Entry Accessed/Dirty Write-Back Calculator

This block decides, after a leaf page-table entry has passed its permission check, whether that entry must be written back to memory. It also produces the value to write. It looks at three inputs: the eight standard attribute bits, the ten extension bits and the kind of access being made. It then marks the entry as accessed, as data-dirty, as capability-dirty, or any mix of the three. The capability-dirty flag works like the ordinary write/dirty pair. It is set only by a capability store to a page whose capability-write permission is set.

The block is purely combinational. It has no clock and no internal state, so its outputs follow its inputs within the same cycle. It carries no data stream, so there is no valid/ready handshake and no back-pressure. The walker registers the inputs and outputs around it and performs the atomic compare-and-swap when the write-back flag is raised. A capability store to a page without capability-write permission must trap; that trap is raised elsewhere, and this block simply never sets the capability-dirty flag in that case.

Attribute bit positions: V=0, R=1, W=2, X=3, U=4, G=5, A=6, D=7. Extension bit positions: capability-write CW=9, capability-read CR=8, capability-dirty CD=7, read-trap=6, read-generation=5, with bits 4..0 reserved.

Top module: `pte_wb_calc`

## Requirements
- R1: When attribute bit A (bit 6) is 0, wb_req_o is 1 and attr_o bit 6 is 1. Whenever wb_req_o is 1, attr_o bit 6 is 1.
- R2: When attribute bit D (bit 7) is 0 and the access has a store side (acc_kind_i 3, 4, 5 or 6), wb_req_o is 1 and attr_o bit 7 is 1.
- R3: When extension bit CW (bit 9) is 1, bit CD (bit 7) is 0, and acc_kind_i is 4 (capability store) or 6 (read-modify-write with a capability store side), wb_req_o is 1 and ext_o bit 7 is 1.
- R4: A capability store never sets ext_o bit 7 when CW is 0. A capability store to an entry with CW=1, CD=1, A=1 and D=1 raises no write-back.
- R5: Execute (kind 0), data load (kind 1), capability load (kind 2), data store (kind 3) and read-modify-write with a data store side (kind 5) never set ext_o bit 7.
- R6: When A=1 and neither the data-dirty nor the capability-dirty update applies, wb_req_o is 0 and attr_o and ext_o equal attr_i and ext_i.
- R7: Every extension bit other than bit 7, including the reserved bits 4..0, passes through unchanged. Every attribute bit other than bits 6 and 7 passes through unchanged.
- R8: acc_kind_i value 7 is treated as having no store side. It never sets D or CD, but it still sets A when A is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| attr_i | input | 8 | Standard attribute bits of the leaf entry |
| ext_i | input | 10 | Extension bits of the leaf entry |
| acc_kind_i | input | 3 | Access kind: 0 execute, 1 data load, 2 capability load, 3 data store, 4 capability store, 5 read-modify-write with data store side, 6 read-modify-write with capability store side, 7 no store side |
| wb_req_o | output | 1 | The entry must be written back |
| attr_o | output | 8 | Attribute bits to write back |
| ext_o | output | 10 | Extension bits to write back |

## Verification
The block holds no state, so an internal fault shows up at the ports in the same cycle as the input that exposes it. A wrong store-side decode shows as a D or CD bit that is set when it should not be, or left clear when it should be set. A wrong pass-through shows as a changed reserved or permission bit. The vectors pair each access kind with entries that are already dirty and with entries that are still clean, so that both a missing update and a spurious update appear as a mismatch of the flag or of the written-back value.

// File: rtl/pte_wb_pkg.sv
package pte_wb_pkg;
  typedef enum logic [2:0] {
    ACC_EXEC     = 3'd0,
    ACC_LD_DATA  = 3'd1,
    ACC_LD_CAP   = 3'd2,
    ACC_ST_DATA  = 3'd3,
    ACC_ST_CAP   = 3'd4,
    ACC_RMW_DATA = 3'd5,
    ACC_RMW_CAP  = 3'd6,
    ACC_NONE     = 3'd7
  } acc_kind_e;
endpackage

// File: rtl/pte_acc_decode.sv
module pte_acc_decode
  import pte_wb_pkg::*;
(
  input  logic [2:0] kind_i,
  output logic       st_any_o,
  output logic       st_cap_o
);
  always_comb begin
    st_any_o = 1'b0;
    st_cap_o = 1'b0;
    case (acc_kind_e'(kind_i))
      ACC_ST_DATA, ACC_RMW_DATA: st_any_o = 1'b1;
      ACC_ST_CAP, ACC_RMW_CAP: begin
        st_any_o = 1'b1;
        st_cap_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pte_ext_upd.sv
module pte_ext_upd #(
  parameter int EXT_W  = 10,
  parameter int CW_POS = 9,
  parameter int CD_POS = 7
) (
  input  logic [EXT_W-1:0] ext_i,
  input  logic             st_cap_i,
  output logic             need_cd_o,
  output logic [EXT_W-1:0] ext_o
);
  assign need_cd_o = st_cap_i & ext_i[CW_POS] & ~ext_i[CD_POS];

  for (genvar gi = 0; gi < EXT_W; gi++) begin : g_bit
    if (gi == CD_POS) begin : g_cd
      assign ext_o[gi] = ext_i[gi] | need_cd_o;
    end else begin : g_pass
      assign ext_o[gi] = ext_i[gi];
    end
  end
endmodule

// File: rtl/pte_attr_upd.sv
module pte_attr_upd #(
  parameter int ATTR_W = 8,
  parameter int A_POS  = 6,
  parameter int D_POS  = 7
) (
  input  logic [ATTR_W-1:0] attr_i,
  input  logic              st_any_i,
  input  logic              need_cd_i,
  output logic              wb_o,
  output logic [ATTR_W-1:0] attr_o
);
  logic need_a, need_d;

  assign need_a = ~attr_i[A_POS];
  assign need_d = st_any_i & ~attr_i[D_POS];
  assign wb_o   = need_a | need_d | need_cd_i;

  always_comb begin
    attr_o = attr_i;
    if (wb_o) attr_o[A_POS] = 1'b1;
    if (need_d) attr_o[D_POS] = 1'b1;
  end
endmodule

// File: rtl/pte_wb_calc.sv
module pte_wb_calc #(
  parameter int ATTR_W = 8,
  parameter int EXT_W  = 10,
  parameter int A_POS  = 6,
  parameter int D_POS  = 7,
  parameter int CW_POS = 9,
  parameter int CD_POS = 7
) (
  input  logic [ATTR_W-1:0] attr_i,
  input  logic [EXT_W-1:0]  ext_i,
  input  logic [2:0]        acc_kind_i,
  output logic              wb_req_o,
  output logic [ATTR_W-1:0] attr_o,
  output logic [EXT_W-1:0]  ext_o
);
  localparam logic [EXT_W-1:0] CD_MASK = EXT_W'(1) << CD_POS;
  localparam logic [ATTR_W-1:0] AD_MASK = (ATTR_W'(1) << A_POS) | (ATTR_W'(1) << D_POS);

  logic st_any, st_cap, need_cd;

  pte_acc_decode u_dec (
    .kind_i   (acc_kind_i),
    .st_any_o (st_any),
    .st_cap_o (st_cap)
  );

  pte_ext_upd #(.EXT_W(EXT_W), .CW_POS(CW_POS), .CD_POS(CD_POS)) u_ext (
    .ext_i     (ext_i),
    .st_cap_i  (st_cap),
    .need_cd_o (need_cd),
    .ext_o     (ext_o)
  );

  pte_attr_upd #(.ATTR_W(ATTR_W), .A_POS(A_POS), .D_POS(D_POS)) u_attr (
    .attr_i    (attr_i),
    .st_any_i  (st_any),
    .need_cd_i (need_cd),
    .wb_o      (wb_req_o),
    .attr_o    (attr_o)
  );

  always_comb begin
    AST_WB_SETS_ACCESSED: assert (!wb_req_o || attr_o[A_POS]); // R1
    AST_DIRTY_NEEDS_STORE: assert (!(attr_o[D_POS] && !attr_i[D_POS]) || st_any); // R2
    AST_CAPDIRTY_NEEDS_CW: assert (!(ext_o[CD_POS] && !ext_i[CD_POS]) || (ext_i[CW_POS] && st_cap)); // R4
    AST_IDLE_PASSTHRU: assert (wb_req_o || (attr_o == attr_i && ext_o == ext_i)); // R6
    AST_EXT_OTHERS_KEPT: assert (((ext_o ^ ext_i) & ~CD_MASK) == '0); // R7
    AST_ATTR_OTHERS_KEPT: assert (((attr_o ^ attr_i) & ~AD_MASK) == '0); // R7
  end
endmodule

// File: tb/test_pte_wb_calc.sv
module test_pte_wb_calc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] attr;
  logic [9:0] ext;
  logic [2:0] kind;
  logic       wb;
  logic [7:0] attr_q;
  logic [9:0] ext_q;

  pte_wb_calc i_pte_wb_calc (
    .attr_i     (attr),
    .ext_i      (ext),
    .acc_kind_i (kind),
    .wb_req_o   (wb),
    .attr_o     (attr_q),
    .ext_o      (ext_q)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // {kind, attr, ext, exp_wb, exp_attr, exp_ext}
  localparam int NV = 12;
  localparam logic [39:0] VEC [NV] = '{
    {3'd0, 8'h0B, 10'h300, 1'b1, 8'h4B, 10'h300}, // R1 execute, A clear
    {3'd1, 8'h43, 10'h300, 1'b0, 8'h43, 10'h300}, // R6 data load, A set
    {3'd3, 8'h47, 10'h200, 1'b1, 8'hC7, 10'h200}, // R2 R5 data store
    {3'd4, 8'hC7, 10'h300, 1'b1, 8'hC7, 10'h380}, // R3 capability store
    {3'd4, 8'hC7, 10'h380, 1'b0, 8'hC7, 10'h380}, // R4 already cap-dirty
    {3'd4, 8'hC7, 10'h100, 1'b0, 8'hC7, 10'h100}, // R4 CW clear
    {3'd6, 8'h07, 10'h21F, 1'b1, 8'hC7, 10'h29F}, // R3 R7 rmw cap store
    {3'd5, 8'h47, 10'h21F, 1'b1, 8'hC7, 10'h21F}, // R5 R2 rmw data store
    {3'd2, 8'h43, 10'h361, 1'b0, 8'h43, 10'h361}, // R5 capability load
    {3'd7, 8'h07, 10'h200, 1'b1, 8'h47, 10'h200}, // R8 kind 7, A clear
    {3'd7, 8'h47, 10'h200, 1'b0, 8'h47, 10'h200}, // R8 kind 7, A set
    {3'd3, 8'h37, 10'h3FF, 1'b1, 8'hF7, 10'h3FF}  // R7 other bits kept
  };
  localparam int VREQ [NV] = '{1, 6, 2, 3, 4, 4, 3, 5, 5, 8, 8, 7};

  task automatic check(input string req, input logic ew, input logic [7:0] ea,
                       input logic [9:0] ee);
    n_chk++;
    if (wb !== ew || attr_q !== ea || ext_q !== ee) begin
      n_bad++;
      $display("FAIL %s: got wb=%b attr=%h ext=%h, expected wb=%b attr=%h ext=%h",
               req, wb, attr_q, ext_q, ew, ea, ee);
    end
  endtask

  task automatic apply(input logic [2:0] k, input logic [7:0] a, input logic [9:0] e);
    @(negedge clk);
    kind = k;
    attr = a;
    ext  = e;
    #1;
  endtask

  initial begin
    kind = 3'd0;
    attr = 8'h00;
    ext  = 10'h000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Inputs at zero after reset: A clear -> write-back with A set (R1)
    apply(3'd0, 8'h00, 10'h000);
    check("R1", 1'b1, 8'h40, 10'h000);
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][39:37], VEC[i][36:29], VEC[i][28:19]);
      check($sformatf("R%0d", VREQ[i]), VEC[i][18], VEC[i][17:10], VEC[i][9:0]);
    end
    // R3: every other bit set, CD clear, rmw with capability store
    apply(3'd6, 8'hFF, 10'h37F);
    check("R3", 1'b1, 8'hFF, 10'h3FF);
    // R4: fully settled entry, capability store, nothing to write
    apply(3'd4, 8'hFF, 10'h3FF);
    check("R4", 1'b0, 8'hFF, 10'h3FF);
    // R5: data store to clean entry with CW set leaves CD clear
    apply(3'd3, 8'hC7, 10'h300);
    check("R5", 1'b0, 8'hC7, 10'h300);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule